// File: doc/BRIEF.md
# Daisy-Chain Arbitration Node and Chain

This block lets several peripherals share one resource without a central arbiter. Each peripheral gets one arbitration node. The nodes are wired in series, with node 0 next to the resource. Request lines are ORed on their way down the chain to the resource. The resource's acknowledge then travels up the chain. The first node on that path that has a pending request keeps the acknowledge and raises its local grant. Nodes without a request pass the acknowledge on to the next node. Priority therefore comes only from position: the node nearest the resource wins. Priority never rotates.

Each node records its keep-or-pass choice in the cycle where its acknowledge input rises. It holds that choice until the acknowledge falls. A request that arrives or goes away mid-acknowledge cannot move the grant. The wrapper instantiates `NODES` nodes and ties the request input of the farthest node to 0. It exposes the acknowledge that leaves the farthest node, so an acknowledge that nobody claimed can be observed.

All chain paths are combinational. The only registers are the per-node decision latches, which sample on the rising clock edge and use an asynchronous active-low reset.

Top module: `dc_arb_chain`

## Requirements
- R1: `res_req` is high in the same cycle as any bit of `dev_req` is high, and low when all bits are low.
- R2: In a cycle where `res_ack` is 1 and was 0 in the previous cycle (or is the first cycle after reset), `dev_grant` is one-hot on the lowest-numbered set bit of `dev_req`. Bit 0 is the node nearest the resource.
- R3: At most one bit of `dev_grant` is high in any cycle.
- R4: While `res_ack` stays high, `dev_grant` does not change, whatever `dev_req` does. This covers a granted device dropping its request and a nearer device raising one.
- R5: When `dev_req` is all zero at the rising cycle of `res_ack`, no grant is given. `tail_ack` then follows `res_ack` until it falls. `tail_ack` is never high together with a grant.
- R6: In any cycle where `res_ack` is 0, `dev_grant` is all zero and `tail_ack` is 0.
- R7: After `res_ack` falls, the next rise arbitrates afresh on the `dev_req` value of that rising cycle. Nothing from the previous acknowledge carries over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NODES | Local request per node; bit 0 is nearest the resource |
| res_ack | input | 1 | Acknowledge from the shared resource |
| res_req | output | 1 | Combined request to the resource |
| dev_grant | output | NODES | Local grant per node |
| tail_ack | output | 1 | Acknowledge leaving the farthest node (unclaimed) |

## Verification
A stuck or wrongly cleared decision latch shows up at the ports in the very next acknowledge cycle. It appears either as a grant that moves while `res_ack` stays high, or as a leftover grant or `tail_ack` after `res_ack` drops. A node that forwards when it should keep shows up in the rising cycle itself, as two grants or a grant on a node that is not the lowest requester. The sweep therefore pairs every request pattern at the rise with every pattern during the hold. It checks the grant in the rising cycle, in each hold cycle, and in the cycle after the fall.

// File: rtl/dc_arb_pkg.sv
package dc_arb_pkg;

  // Decision held by a node for the current acknowledge
  typedef enum logic [1:0] {
    ND_IDLE = 2'd0,
    ND_KEEP = 2'd1,
    ND_PASS = 2'd2
  } node_dec_e;

endpackage

// File: rtl/dc_ack_latch.sv
module dc_ack_latch
  import dc_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic want_i,
  output logic rise_o,
  output logic take_o
);

  logic      ack_q;
  node_dec_e dec_q;
  node_dec_e dec_d;

  assign rise_o = ack_i & ~ack_q;

  // Keep the acknowledge: at the rise, decided live; afterwards, from the latch
  always_comb begin
    if (!ack_i)      take_o = 1'b0;
    else if (rise_o) take_o = want_i;
    else             take_o = (dec_q == ND_KEEP);
  end

  always_comb begin
    if (!ack_i)      dec_d = ND_IDLE;
    else if (rise_o) dec_d = want_i ? ND_KEEP : ND_PASS;
    else             dec_d = dec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      dec_q <= ND_IDLE;
    end else begin
      ack_q <= ack_i;
      dec_q <= dec_d;
    end
  end

  // R6 / R7: a low acknowledge leaves no decision behind
  assert_dec_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> (dec_q == ND_IDLE));

  // R4: once settled, the decision does not flip while ack stays high
  assert_dec_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ack_q && dec_q != ND_IDLE) |=> (!ack_i || dec_q == $past(dec_q)));

endmodule

// File: rtl/dc_arb_node.sv
module dc_arb_node (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_req_i,
  input  logic req_in_i,
  output logic req_out_o,
  input  logic ack_in_i,
  output logic ack_out_o,
  output logic grant_o
);

  logic ack_rise;
  logic ack_take;

  assign req_out_o = dev_req_i | req_in_i;

  dc_ack_latch i_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_i  (ack_in_i),
    .want_i (dev_req_i),
    .rise_o (ack_rise),
    .take_o (ack_take)
  );

  assign grant_o   = ack_take;
  assign ack_out_o = ack_in_i & ~ack_take;

  // R6: neither output can carry an acknowledge the node did not receive
  assert_grant_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> ack_in_i);
  assert_fwd_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out_o |-> ack_in_i);
  // R3: a node never both keeps and forwards
  assert_keep_xor_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && ack_out_o));
  // R2: at the rise a requesting node keeps the acknowledge
  assert_rise_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && dev_req_i) |-> grant_o);

endmodule

// File: rtl/dc_arb_chain.sv
module dc_arb_chain #(
  parameter int NODES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] dev_req,
  input  logic             res_ack,
  output logic             res_req,
  output logic [NODES-1:0] dev_grant,
  output logic             tail_ack
);

  localparam int LINKS = NODES + 1;

  logic [LINKS-1:0] req_link;
  logic [LINKS-1:0] ack_link;

  // Farthest node sees no upstream request
  assign req_link[NODES] = 1'b0;
  assign ack_link[0]     = res_ack;

  for (genvar gi = 0; gi < NODES; gi++) begin : g_node
    dc_arb_node i_node (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_req_i (dev_req[gi]),
      .req_in_i  (req_link[gi+1]),
      .req_out_o (req_link[gi]),
      .ack_in_i  (ack_link[gi]),
      .ack_out_o (ack_link[gi+1]),
      .grant_o   (dev_grant[gi])
    );
  end

  assign res_req  = req_link[0];
  assign tail_ack = ack_link[NODES];

  // Lowest set bit: the winner expected by position
  function automatic logic [NODES-1:0] nearest_req(input logic [NODES-1:0] v);
    return v & (~v + NODES'(1));
  endfunction

  // Observation state for the assertions only
  logic             ack_seen_q;
  logic [NODES-1:0] grant_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_seen_q <= 1'b0;
      grant_q    <= '0;
    end else begin
      ack_seen_q <= res_ack;
      grant_q    <= dev_grant;
    end
  end
  logic ack_up;
  assign ack_up = res_ack & ~ack_seen_q;

  assert_req_merge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_req == (|dev_req));
  assert_nearest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_up |-> (dev_grant == nearest_req(dev_req)));
  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));
  assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ack && ack_seen_q) |-> (dev_grant == grant_q));
  assert_tail_unclaimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tail_ack |-> (res_ack && dev_grant == '0));
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ack |-> (dev_grant == '0 && !tail_ack));

endmodule

// File: tb/test_dc_arb_chain.sv
module test_dc_arb_chain;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic         res_ack = 1'b0;
  logic         res_req;
  logic [N-1:0] dev_grant;
  logic         tail_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dc_arb_chain #(.NODES(N)) i_dc_arb_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .res_ack   (res_ack),
    .res_req   (res_req),
    .dev_grant (dev_grant),
    .tail_ack  (tail_ack)
  );

  // Winner by position: index of the smallest set bit, as a one-hot
  function automatic logic [N-1:0] want_grant(input int pattern);
    for (int k = 0; k < N; k++)
      if (((pattern >> k) & 1) == 1) return N'(1 << k);
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (req=%b ack=%b)", req, act, exp, dev_req, res_ack);
    end
  endtask

  // Drive after the falling edge, sample shortly after
  task automatic drive(input logic [N-1:0] r, input logic a);
    @(negedge clk);
    dev_req = r;
    res_ack = a;
    #2;
    check("R1 res_req", 32'(res_req), 32'(r != 0));
  endtask

  task automatic one_round(input int first, input int later);
    logic [N-1:0] g;
    drive(N'(first), 1'b1);
    g = want_grant(first);
    check("R2 grant at rise", 32'(dev_grant), 32'(g));
    check("R3 grant count", 32'($countones(dev_grant)), 32'(g != 0));
    check("R5 tail at rise", 32'(tail_ack), 32'(first == 0));
    for (int h = 0; h < 2; h++) begin
      drive(N'(h == 0 ? later : later ^ first), 1'b1);
      check("R4 grant held", 32'(dev_grant), 32'(g));
      check("R5 tail held", 32'(tail_ack), 32'(first == 0));
    end
    drive(N'(later), 1'b0);
    check("R6 grant after fall", 32'(dev_grant), 32'(0));
    check("R6 tail after fall", 32'(tail_ack), 32'(0));
  endtask

  initial begin
    #3;
    check("reset grant", 32'(dev_grant), 32'(0));
    check("reset tail", 32'(tail_ack), 32'(0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++)
        one_round(a, b);
    // R7: back-to-back acknowledges re-arbitrate on fresh requests
    one_round(4'b1000, 4'b0001);
    one_round(4'b0001, 4'b1000);
    drive(4'b0110, 1'b1);
    check("R7 fresh rise", 32'(dev_grant), 32'(4'b0010));
    drive(4'b0000, 1'b0);
    drive(4'b0100, 1'b1);
    check("R7 fresh rise after drop", 32'(dev_grant), 32'(4'b0100));
    drive(4'b0000, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule